// File: doc/BRIEF.md
# Serial Programming Target Port

This block is the target side of a two-wire serial programming link. The first wire is a clock input. The second is a data line that the host drives, except during read frames, when the block drives it. The block is active only while the programming-mode enable is held high. Both wires are sampled on a fast system clock through a two-flop synchronizer, and the block acts on edges of the synchronized serial clock.

The host first shifts in a 6-bit command and then, for load and read commands, a 16-clock data frame. That frame is a start bit of 0, fourteen data bits sent least significant bit first, and a stop bit of 0. The block keeps a program counter (PC) that selects either the user region or the configuration region. It sends one-cycle requests to an external memory model to read the addressed word, to write the latched word, or to erase everything. When code protection is on, user-memory reads come back as zero.

The FSM has seven states:
- ST_CMD collects the command bits.
- ST_LOAD receives a data frame.
- ST_RD_REQ issues the memory read.
- ST_RD_WAIT captures the returned word.
- ST_READ sends the word out.
- ST_WRITE is a one-cycle write request.
- ST_ERASE is a one-cycle erase request.

Transitions:
- ST_CMD goes to ST_LOAD on either load command.
- ST_CMD goes to ST_RD_REQ on read, then on to ST_RD_WAIT and then ST_READ.
- ST_CMD goes to ST_WRITE on begin programming and to ST_ERASE on erase.
- ST_LOAD and ST_READ return to ST_CMD after the 16th falling edge of the frame.
- ST_WRITE and ST_ERASE return to ST_CMD after one cycle.
- Every other command stays in ST_CMD.
- Dropping the mode enable forces ST_CMD from any state.

Top module: `serial_prog_target`

## Requirements
- R1: Command bits are captured on falling serial-clock edges, bit 0 first, six bits per command. Only the low 4 bits are decoded and bits 4 and 5 are ignored. The codes are: 0x0 load configuration, 0x2 load data, 0x4 read, 0x6 increment, 0x8 begin programming, 0x9 erase, 0xE end programming.
- R2: A load-data frame takes data bit 0 at the 2nd falling edge and bit 13 at the 15th. The latched word appears on `mem_wdata`.
- R3: In a read frame, `sdat_oe` rises at the 2nd rising edge, with data bit 0 on `sdat_out`. One bit follows per rising edge, and the line is released at the 16th rising edge. The start and stop clocks are never driven.
- R4: Mode entry sets the PC to 0x0000 and increment adds one. In the user region the PC wraps from 0x1FFF to 0x0000, which is 2^(PC_W-1)-1 to 0 in general.
- R5: Load configuration sets the PC to 0x2000. Its data word is discarded and the latched write word is unchanged.
- R6: In the configuration region the PC wraps from 0x3FFF to 0x2000. The top PC bit stays set until mode exit.
- R7: `mem_cfg_sel` is high only for PC 0x2000 to 0x203F, which is 0x2000 plus CFG_WIN-1 in general.
- R8: With `code_protect` high, a read with `mem_cfg_sel` low returns zero. Configuration reads are unaffected.
- R9: Begin programming gives exactly one cycle of `mem_wr_req`, and erase gives exactly one cycle of `mem_erase_req`. At most one request is active in any cycle.
- R10: Increment, begin, erase, end and unknown codes take no data frame. Unknown codes change nothing, and the next command is decoded normally.
- R11: Dropping `prog_en` clears all state, including a partly shifted command and the sticky configuration bit.
- R12: `sdat_oe` is low outside read frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_en | input | 1 | Programming-mode enable |
| sclk_pin | input | 1 | Serial clock from the host |
| sdat_pin | input | 1 | Serial data from the host |
| code_protect | input | 1 | User-memory read protection |
| sdat_out | output | 1 | Serial data driven during read frames |
| sdat_oe | output | 1 | Output enable for the data line |
| mem_addr | output | PC_W | Current PC |
| mem_cfg_sel | output | 1 | PC lies in the configuration window |
| mem_rd_req | output | 1 | One-cycle read request |
| mem_rdata | input | DATA_W | Read word, valid the cycle after `mem_rd_req` |
| mem_wr_req | output | 1 | One-cycle write request |
| mem_wdata | output | DATA_W | Latched word to write |
| mem_erase_req | output | 1 | One-cycle erase request |

## Verification
The PC wrap points are hard to reach from the pins, because every increment costs a full six-clock serial command and reaching either wrap at the default width takes thousands of them. The bench therefore adds a second instance with a 7-bit PC and an 8-word configuration window. It shares the same serial stimulus as the first instance and walks through both wraps and both window edges with a few hundred commands. A partly shifted command dropped by a mode exit is produced by pulsing only three command bits before lowering the enable.

// File: rtl/spt_pkg.sv
package spt_pkg;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_LOAD,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_READ,
        ST_WRITE,
        ST_ERASE
    } spt_state_e;

    typedef enum logic [2:0] {
        OP_LOAD_CFG,
        OP_LOAD_DATA,
        OP_READ,
        OP_INC,
        OP_BEGIN,
        OP_ERASE,
        OP_END,
        OP_NONE
    } spt_op_e;

    localparam logic [3:0] CODE_LOAD_CFG  = 4'h0;
    localparam logic [3:0] CODE_LOAD_DATA = 4'h2;
    localparam logic [3:0] CODE_READ      = 4'h4;
    localparam logic [3:0] CODE_INC       = 4'h6;
    localparam logic [3:0] CODE_BEGIN     = 4'h8;
    localparam logic [3:0] CODE_ERASE     = 4'h9;
    localparam logic [3:0] CODE_END       = 4'hE;

    localparam int CMD_BITS   = 6;
    localparam int FRAME_BITS = 16;

endpackage

// File: rtl/spt_sync.sv
module spt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_pin,
    input  logic sdat_pin,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sdat_s
);
    logic [STAGES:0]   sclk_q;
    logic [STAGES-1:0] sdat_q;

    generate
        for (genvar i = 0; i <= STAGES; i++) begin : g_clk
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      sclk_q[i] <= 1'b0;
                else if (i == 0) sclk_q[i] <= sclk_pin;
                else             sclk_q[i] <= sclk_q[(i == 0) ? 0 : i-1];
            end
        end
        for (genvar j = 0; j < STAGES; j++) begin : g_dat
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      sdat_q[j] <= 1'b0;
                else if (j == 0) sdat_q[j] <= sdat_pin;
                else             sdat_q[j] <= sdat_q[(j == 0) ? 0 : j-1];
            end
        end
    endgenerate

    assign sclk_rise =  sclk_q[STAGES-1] & ~sclk_q[STAGES];
    assign sclk_fall = ~sclk_q[STAGES-1] &  sclk_q[STAGES];
    assign sdat_s    =  sdat_q[STAGES-1];
endmodule

// File: rtl/spt_cmd_decode.sv
module spt_cmd_decode
    import spt_pkg::*;
(
    input  logic [3:0] code,
    output spt_op_e    op
);
    always_comb begin
        unique case (code)
            CODE_LOAD_CFG:  op = OP_LOAD_CFG;
            CODE_LOAD_DATA: op = OP_LOAD_DATA;
            CODE_READ:      op = OP_READ;
            CODE_INC:       op = OP_INC;
            CODE_BEGIN:     op = OP_BEGIN;
            CODE_ERASE:     op = OP_ERASE;
            CODE_END:       op = OP_END;
            default:        op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/spt_pc.sv
module spt_pc #(
    parameter int PC_W    = 14,
    parameter int CFG_WIN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            set_cfg,
    input  logic            inc,
    output logic [PC_W-1:0] pc,
    output logic            cfg_sel
);
    localparam int LOW_W = PC_W - 1;
    localparam logic [LOW_W-1:0] WIN_LIM = LOW_W'(CFG_WIN);

    logic [LOW_W-1:0] low;
    logic             top;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top <= 1'b0;
            low <= '0;
        end else if (clr) begin
            top <= 1'b0;
            low <= '0;
        end else if (set_cfg) begin
            top <= 1'b1;
            low <= '0;
        end else if (inc) begin
            low <= low + 1'b1;
        end
    end

    assign pc      = {top, low};
    assign cfg_sel = top && (low < WIN_LIM);
endmodule

// File: rtl/serial_prog_target.sv
module serial_prog_target
    import spt_pkg::*;
#(
    parameter int PC_W        = 14,
    parameter int DATA_W      = 14,
    parameter int CFG_WIN     = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic              sclk_pin,
    input  logic              sdat_pin,
    input  logic              code_protect,
    output logic              sdat_out,
    output logic              sdat_oe,
    output logic [PC_W-1:0]   mem_addr,
    output logic              mem_cfg_sel,
    output logic              mem_rd_req,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_wr_req,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_erase_req
);
    localparam int CNT_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] DATA_FIRST = CNT_W'(1);
    localparam logic [CNT_W-1:0] DATA_LAST  = CNT_W'(DATA_W);

    spt_state_e        state, nxt;
    spt_op_e           op;
    logic              sclk_rise, sclk_fall, sdat_s;
    logic [CNT_W-1:0]  bit_cnt;
    logic [3:0]        cmd_sr;
    logic [DATA_W-1:0] in_sr, wlatch, out_sr;
    logic              keep_load, oe_q, out_q;
    logic              cmd_done, pc_inc, pc_cfg;

    spt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sclk_pin(sclk_pin), .sdat_pin(sdat_pin),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sdat_s(sdat_s)
    );

    spt_cmd_decode u_dec (.code(cmd_sr), .op(op));

    spt_pc #(.PC_W(PC_W), .CFG_WIN(CFG_WIN)) u_pc (
        .clk(clk), .rst_n(rst_n), .clr(!prog_en), .set_cfg(pc_cfg),
        .inc(pc_inc), .pc(mem_addr), .cfg_sel(mem_cfg_sel)
    );

    assign cmd_done = (state == ST_CMD) && sclk_fall && (bit_cnt == CMD_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state <= ST_CMD;
        else if (!prog_en) state <= ST_CMD;
        else               state <= nxt;
    end

    // next state and PC controls
    always_comb begin
        nxt    = state;
        pc_inc = 1'b0;
        pc_cfg = 1'b0;
        unique case (state)
            ST_CMD: begin
                if (cmd_done) begin
                    unique case (op)
                        OP_LOAD_CFG: begin
                            nxt    = ST_LOAD;
                            pc_cfg = 1'b1;
                        end
                        OP_LOAD_DATA: nxt    = ST_LOAD;
                        OP_READ:      nxt    = ST_RD_REQ;
                        OP_INC:       pc_inc = 1'b1;
                        OP_BEGIN:     nxt    = ST_WRITE;
                        OP_ERASE:     nxt    = ST_ERASE;
                        default:      nxt    = ST_CMD;
                    endcase
                end
            end
            ST_LOAD, ST_READ: begin
                if (sclk_fall && bit_cnt == FRAME_LAST) nxt = ST_CMD;
            end
            ST_RD_REQ:  nxt = ST_RD_WAIT;
            ST_RD_WAIT: nxt = ST_READ;
            ST_WRITE:   nxt = ST_CMD;
            ST_ERASE:   nxt = ST_CMD;
            default:    nxt = ST_CMD;
        endcase
    end

    // Moore request outputs
    always_comb begin
        mem_rd_req    = (state == ST_RD_REQ);
        mem_wr_req    = (state == ST_WRITE);
        mem_erase_req = (state == ST_ERASE);
        mem_wdata     = wlatch;
        sdat_oe       = oe_q;
        sdat_out      = out_q;
    end

    // serial datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || !prog_en) begin
            bit_cnt   <= '0;
            cmd_sr    <= '0;
            in_sr     <= '0;
            wlatch    <= '0;
            out_sr    <= '0;
            keep_load <= 1'b0;
            oe_q      <= 1'b0;
            out_q     <= 1'b0;
        end else begin
            unique case (state)
                ST_CMD: begin
                    if (sclk_fall) begin
                        if (bit_cnt < CNT_W'(4)) cmd_sr <= {sdat_s, cmd_sr[3:1]};
                        bit_cnt <= (bit_cnt == CMD_LAST) ? '0 : bit_cnt + 1'b1;
                    end
                    if (cmd_done) keep_load <= (op == OP_LOAD_DATA);
                end
                ST_LOAD: begin
                    if (sclk_fall) begin
                        if (bit_cnt >= DATA_FIRST && bit_cnt <= DATA_LAST)
                            in_sr <= {sdat_s, in_sr[DATA_W-1:1]};
                        if (bit_cnt == FRAME_LAST && keep_load) wlatch <= in_sr;
                        bit_cnt <= (bit_cnt == FRAME_LAST) ? '0 : bit_cnt + 1'b1;
                    end
                end
                ST_RD_WAIT: begin
                    out_sr <= (code_protect && !mem_cfg_sel) ? '0 : mem_rdata;
                end
                ST_READ: begin
                    if (sclk_rise) begin
                        if (bit_cnt == FRAME_LAST) begin
                            oe_q  <= 1'b0;
                            out_q <= 1'b0;
                        end else if (bit_cnt >= DATA_FIRST && bit_cnt <= DATA_LAST) begin
                            oe_q   <= 1'b1;
                            out_q  <= out_sr[0];
                            out_sr <= out_sr >> 1;
                        end
                    end
                    if (sclk_fall)
                        bit_cnt <= (bit_cnt == FRAME_LAST) ? '0 : bit_cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/spt_checker.sv
module spt_checker #(
    parameter int PC_W = 14
) (
    input logic            clk,
    input logic            rst_n,
    input logic            prog_en,
    input logic            sclk_rise,
    input logic            sdat_oe,
    input logic            mem_rd_req,
    input logic            mem_wr_req,
    input logic            mem_erase_req,
    input logic [PC_W-1:0] mem_addr
);
    assert_req_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_req, mem_wr_req, mem_erase_req}));

    assert_wr_single_R9: assert property (@(posedge clk) disable iff (!rst_n || !prog_en)
        mem_wr_req |=> !mem_wr_req);

    assert_erase_single_R9: assert property (@(posedge clk) disable iff (!rst_n || !prog_en)
        mem_erase_req |=> !mem_erase_req);

    assert_cfg_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n || !prog_en)
        mem_addr[PC_W-1] |=> mem_addr[PC_W-1]);

    assert_entry_pc_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_en) |-> (mem_addr == '0));

    assert_oe_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n || !prog_en)
        $rose(sdat_oe) |-> $past(sclk_rise));

    assert_oe_off_R3: assert property (@(posedge clk) disable iff (!rst_n || !prog_en)
        $fell(sdat_oe) |-> ($past(sclk_rise) || !$past(prog_en)));

    assert_no_drive_at_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !sdat_oe);
endmodule

bind serial_prog_target spt_checker #(.PC_W(PC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .sclk_rise(sclk_rise),
    .sdat_oe(sdat_oe), .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req),
    .mem_erase_req(mem_erase_req), .mem_addr(mem_addr)
);

// File: tb/sim_serial_prog_target.sv
`timescale 1ns/1ps
module sim_serial_prog_target;
    localparam int HALF = 5;
    localparam int NV   = 8;
    // {cmd[33:28], data[27:14], expected pc[13:0]}
    localparam logic [33:0] VEC [NV] = '{
        {6'h06, 14'h0000, 14'h0001},   // R1 increment
        {6'h36, 14'h0000, 14'h0002},   // R1 bits 4,5 ignored
        {6'h12, 14'h1234, 14'h0002},   // R2 load data, pc unchanged
        {6'h03, 14'h0000, 14'h0002},   // R10 unknown code
        {6'h06, 14'h0000, 14'h0003},   // R4 increment
        {6'h00, 14'h3FFF, 14'h2000},   // R5 load configuration
        {6'h0F, 14'h0000, 14'h2000},   // R10 unknown code
        {6'h26, 14'h0000, 14'h2001}    // R6 increment in config region
    };

    logic clk = 1'b0, rst_n = 1'b0, prog_en = 1'b0;
    logic sclk = 1'b0, sdat = 1'b0, cp = 1'b0;
    logic sdat_out, sdat_oe, cfg_sel, rd_req, wr_req, er_req;
    logic [13:0] addr, wdata;
    logic [13:0] rdata = '0;
    logic s_out1, s_oe1, cfg1, rd1, wr1, er1;
    logic [6:0]  addr1;
    logic [13:0] wdata1;

    int errors = 0, checks = 0;
    int wr_cnt = 0, er_cnt = 0;
    logic [13:0] last_wa = '0, last_wd = '0;

    always #10 clk = ~clk;

    serial_prog_target u0 (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .sclk_pin(sclk), .sdat_pin(sdat),
        .code_protect(cp), .sdat_out(sdat_out), .sdat_oe(sdat_oe), .mem_addr(addr),
        .mem_cfg_sel(cfg_sel), .mem_rd_req(rd_req), .mem_rdata(rdata),
        .mem_wr_req(wr_req), .mem_wdata(wdata), .mem_erase_req(er_req)
    );

    serial_prog_target #(.PC_W(7), .CFG_WIN(8)) u1 (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .sclk_pin(sclk), .sdat_pin(sdat),
        .code_protect(cp), .sdat_out(s_out1), .sdat_oe(s_oe1), .mem_addr(addr1),
        .mem_cfg_sel(cfg1), .mem_rd_req(rd1), .mem_rdata(14'h0000),
        .mem_wr_req(wr1), .mem_wdata(wdata1), .mem_erase_req(er1)
    );

    function automatic logic [13:0] model(input logic [13:0] a, input logic sel);
        if (sel) return 14'h0A00 | {10'd0, a[3:0]};
        return ({1'b0, a[12:0]} * 14'd7) + 14'h0155;
    endfunction

    always @(posedge clk) begin
        if (rd_req) rdata <= model(addr, cfg_sel);
        if (wr_req) begin wr_cnt <= wr_cnt + 1; last_wa <= addr; last_wd <= wdata; end
        if (er_req) er_cnt <= er_cnt + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic b);
        sdat = b;
        wait_n(HALF);
        sclk = 1'b1;
        wait_n(HALF);
        sclk = 1'b0;
        wait_n(HALF);
    endtask

    task automatic send_cmd(input logic [5:0] c);
        for (int i = 0; i < 6; i++) pulse(c[i]);
        wait_n(8);
    endtask

    task automatic send_frame(input logic [13:0] d);
        pulse(1'b0);
        for (int i = 0; i < 14; i++) pulse(d[i]);
        pulse(1'b0);
        wait_n(8);
    endtask

    task automatic read_frame(output logic [13:0] w, output logic oe_ok);
        oe_ok = 1'b1;
        w = '0;
        sdat = 1'b0;
        for (int k = 1; k <= 16; k++) begin
            sclk = 1'b1;
            wait_n(HALF);
            if (sdat_oe !== ((k >= 2) && (k <= 15))) oe_ok = 1'b0;
            if (k >= 2 && k <= 15) w[k-2] = sdat_out;
            sclk = 1'b0;
            wait_n(HALF);
        end
        wait_n(8);
        if (sdat_oe !== 1'b0) oe_ok = 1'b0;
    endtask

    task automatic mode_cycle;
        prog_en = 1'b0;
        wait_n(4);
        prog_en = 1'b1;
        wait_n(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [13:0] w;
        logic ok;
        int wc, ec;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(4);
        prog_en = 1'b1;
        wait_n(4);
        chk("R4 reset pc", addr, 14'h0000);
        chk("R12 reset oe", sdat_oe, 1'b0);
        chk("R9 no requests at reset", wr_cnt + er_cnt, 0);

        for (int v = 0; v < NV; v++) begin
            send_cmd(VEC[v][33:28]);
            if (VEC[v][31:28] == 4'h0 || VEC[v][31:28] == 4'h2) send_frame(VEC[v][27:14]);
            chk("R1/R5/R10 vector pc", addr, VEC[v][13:0]);
        end

        // R11 exit clears sticky config bit
        mode_cycle();
        chk("R11 mode exit clears pc", addr, 14'h0000);

        // R2 load and program
        send_cmd(6'h02); send_frame(14'h2A5C);
        wc = wr_cnt;
        send_cmd(6'h08);
        chk("R9 single write request", wr_cnt - wc, 1);
        chk("R2 write addr", last_wa, 14'h0000);
        chk("R2 write data", last_wd, 14'h2A5C);
        send_cmd(6'h0E);
        chk("R10 end programming no request", wr_cnt - wc, 1);

        // R5 configuration load discards data
        send_cmd(6'h00); send_frame(14'h3FFF);
        send_cmd(6'h08);
        chk("R5 write addr 0x2000", last_wa, 14'h2000);
        chk("R5 data discarded", last_wd, 14'h2A5C);
        chk("R7 config select at 0x2000", cfg_sel, 1'b1);

        // R3 read of configuration word
        send_cmd(6'h04); read_frame(w, ok);
        chk("R3 read config word", w, 14'h0A00);
        chk("R3 output enable window", ok, 1'b1);

        // R8 config read under protection
        cp = 1'b1;
        send_cmd(6'h06);
        send_cmd(6'h04); read_frame(w, ok);
        chk("R8 protected config read", w, 14'h0A01);

        // R8 user read under protection
        mode_cycle();
        for (int i = 0; i < 5; i++) send_cmd(6'h06);
        send_cmd(6'h04); read_frame(w, ok);
        chk("R8 protected user read zero", w, 14'h0000);
        cp = 1'b0;
        send_cmd(6'h04); read_frame(w, ok);
        chk("R3 user read", w, 14'h0178);
        chk("R12 oe idle after read", sdat_oe, 1'b0);

        // R9 erase
        wc = wr_cnt; ec = er_cnt;
        send_cmd(6'h09);
        chk("R9 single erase request", er_cnt - ec, 1);
        chk("R9 erase issues no write", wr_cnt - wc, 0);

        // R11 partly shifted command
        pulse(1'b0); pulse(1'b1); pulse(1'b1);
        mode_cycle();
        send_cmd(6'h06);
        chk("R11 partial command cleared", addr, 14'h0001);

        // small instance: window edges and wraps
        mode_cycle();
        send_cmd(6'h00); send_frame(14'h0000);
        chk("R7 small window start", {addr1, cfg1}, {7'h40, 1'b1});
        for (int i = 0; i < 7; i++) send_cmd(6'h06);
        chk("R7 small window last", {addr1, cfg1}, {7'h47, 1'b1});
        send_cmd(6'h06);
        chk("R7 beyond window", {addr1, cfg1}, {7'h48, 1'b0});
        for (int i = 0; i < 55; i++) send_cmd(6'h06);
        chk("R6 config top", addr1, 7'h7F);
        send_cmd(6'h06);
        chk("R6 config wrap", addr1, 7'h40);
        mode_cycle();
        for (int i = 0; i < 63; i++) send_cmd(6'h06);
        chk("R4 user top", addr1, 7'h3F);
        send_cmd(6'h06);
        chk("R4 user wrap", addr1, 7'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule